// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block is an 8-bit up-counter driven by one of eight taps of a free-running prescaler on the system clock. It serves either as a periodic interval timer, which raises an interrupt each time the counter wraps, or as a watchdog, which asks for a system reset when software fails to service it before the wrap. Software controls it through a single 8-bit control/status register, read and written over a simple strobe-based port.

Writes carry a 16-bit word. The upper byte is a key, and only a matching key lets the lower byte reach the register, so a stray store cannot reconfigure or silence the timer. The sticky overflow flag can only be cleared by a two-step exchange: read the register while the flag is set, then write 0 to the flag bit. A further overflow between those two steps cancels the exchange. Whether a watchdog overflow actually produces a reset is chosen by an input supplied from outside the block.

Top module: `wdog_itmr`

## Requirements
- R1: After reset the register reads 0x18 (flag 0, interval mode, counter stopped, clock code 0), and both `irq_o` and `rst_req_o` are low.
- R2: Register bits 4 and 3 always read 1, whatever value is written to them.
- R3: A write changes the register only when `reg_wdata_i[15:8]` equals 0xA5. With any other key byte the register contents and any pending clear stay as they were.
- R4: While the run bit (bit 5) is 0 the counter is held at zero and no overflow occurs. Once the bit is set, the first overflow comes between 255 and 256 selected ticks later.
- R5: Clock-select code `c` in bits 2:0 (000 to 111) selects a tick every 2, 64, 128, 512, 2048, 8192, 32768 or 131072 system clocks, in that order. Consecutive overflows are therefore 256 times that many cycles apart.
- R6: With the mode bit (bit 6) at 0, `irq_o` is high exactly while the flag (bit 7) is 1. With the mode bit at 1, `irq_o` stays low.
- R7: The flag is set by a counter wrap from 0xFF to 0x00. A keyed write of 0 to bit 7 clears it only if a read with the flag set came earlier. Without that read the flag stays set.
- R8: If a new overflow occurs after the arming read and before the clearing write, that write leaves the flag set. A fresh read then re-arms the clear.
- R9: In watchdog mode with `rst_gen_en_i` high, an overflow gives a one-cycle `rst_req_o` pulse. In the same cycle the register returns to 0x18, so the flag reads 0 and the counter is stopped.
- R10: In watchdog mode with `rst_gen_en_i` low, an overflow sets the flag and produces neither `irq_o` nor `rst_req_o`.
- R11: Writing 1 to bit 7 never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 16 | Key byte in 15:8, register value in 7:0 |
| reg_rd_i | input | 1 | Read strobe, arms the flag clear when the flag is set |
| reg_rdata_o | output | 8 | Register contents: flag, mode, run, two ones, clock code |
| rst_gen_en_i | input | 1 | Lets a watchdog overflow request a reset |
| irq_o | output | 1 | Interval interrupt request |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The properties assume that reset is held long enough to clear every register, and that read and write strobes are single-cycle events whose data is stable while the strobe is high. They also assume that reset generation is not switched on in the same cycle as an overflow. The stimulus drives every strobe for exactly one cycle, away from the clock edge. It changes `rst_gen_en_i` only while the counter is stopped, and it makes its randomised keyed writes with the run bit cleared, so that overflow timing stays under directed control.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam int unsigned SEL_W  = 3;
   localparam int unsigned N_TAPS = 1 << SEL_W;
   localparam int unsigned REG_W  = 8;
   localparam int unsigned RSV_W  = REG_W - SEL_W - 3;

   // control/status layout, most significant field first
   typedef struct packed {
      logic             ovf;
      logic             wdm;
      logic             run;
      logic [SEL_W-1:0] sel;
   } csr_t;

   // log2 of the division ratio for each clock-select code
   function automatic int unsigned tap_shift(input int unsigned code);
      case (code)
         0:       return 1;
         1:       return 6;
         2:       return 7;
         3:       return 9;
         4:       return 11;
         5:       return 13;
         6:       return 15;
         default: return 17;
      endcase
   endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
   import wdog_pkg::*;
#(
   parameter int unsigned PRE_W = 17
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);

   logic [PRE_W-1:0]  div_q;
   logic [N_TAPS-1:0] tap_tick;

   initial begin : p_param_chk
      assert (PRE_W >= tap_shift(N_TAPS - 1))
         else $error("prescaler narrower than the widest tap");
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) div_q <= '0;
      else         div_q <= div_q + PRE_W'(1);
   end

   // one tick per full cycle of the low SH bits
   for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
      localparam int unsigned SH = tap_shift(t);
      assign tap_tick[t] = &div_q[SH-1:0];
   end

   assign tick_o = tap_tick[sel_i];

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic tick_i,
   output logic wrap_o
);

   logic [CNT_W-1:0] cnt_q;

   initial begin : p_param_chk
      assert (CNT_W >= 2) else $error("counter width below 2");
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (!run_i) cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
   end

   assign wrap_o = run_i & tick_i & (&cnt_q);

endmodule

// File: rtl/wdog_csr.sv
module wdog_csr
   import wdog_pkg::*;
#(
   parameter logic [7:0] WR_KEY = 8'hA5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic [15:0]      wdata_i,
   input  logic             rd_i,
   input  logic             wrap_i,
   input  logic             wd_rst_i,
   output csr_t             csr_o,
   output logic [REG_W-1:0] rdata_o
);

   csr_t csr_q;
   logic arm_q;
   logic key_ok;
   logic clr_ok;
   logic unused_bits;

   assign key_ok      = wr_i && (wdata_i[15:8] == WR_KEY);
   assign clr_ok      = key_ok && !wdata_i[7] && arm_q;
   assign unused_bits = ^wdata_i[4:3];

   always_ff @(posedge clk_i) begin
      if (!rst_ni || wd_rst_i) begin
         csr_q <= '0;
         arm_q <= 1'b0;
      end else begin
         if (key_ok) begin
            csr_q.wdm <= wdata_i[6];
            csr_q.run <= wdata_i[5];
            csr_q.sel <= wdata_i[SEL_W-1:0];
         end
         // a wrap outranks a clear arriving in the same cycle
         if (wrap_i)      csr_q.ovf <= 1'b1;
         else if (clr_ok) csr_q.ovf <= 1'b0;
         // arming read; discarded by any keyed write or a new wrap
         if (wrap_i || key_ok)     arm_q <= 1'b0;
         else if (rd_i && csr_q.ovf) arm_q <= 1'b1;
      end
   end

   assign csr_o   = csr_q;
   assign rdata_o = {csr_q.ovf, csr_q.wdm, csr_q.run, {RSV_W{1'b1}}, csr_q.sel};

endmodule

// File: rtl/wdog_itmr.sv
module wdog_itmr
   import wdog_pkg::*;
#(
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned PRE_W  = 17,
   parameter logic [7:0]  WR_KEY = 8'hA5
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        reg_wr_i,
   input  logic [15:0] reg_wdata_i,
   input  logic        reg_rd_i,
   output logic [7:0]  reg_rdata_o,
   input  logic        rst_gen_en_i,
   output logic        irq_o,
   output logic        rst_req_o
);

   csr_t csr;
   logic tick;
   logic wrap;
   logic wd_rst;
   logic rst_req_q;

   initial begin : p_param_chk
      assert (REG_W == 8) else $error("register must be one byte");
   end

   wdog_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (csr.sel),
      .tick_o (tick)
   );

   wdog_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (csr.run),
      .tick_i (tick),
      .wrap_o (wrap)
   );

   assign wd_rst = wrap & csr.wdm & rst_gen_en_i;

   wdog_csr #(.WR_KEY(WR_KEY)) u_csr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (reg_wr_i),
      .wdata_i  (reg_wdata_i),
      .rd_i     (reg_rd_i),
      .wrap_i   (wrap),
      .wd_rst_i (wd_rst),
      .csr_o    (csr),
      .rdata_o  (reg_rdata_o)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) rst_req_q <= 1'b0;
      else         rst_req_q <= wd_rst;
   end

   assign rst_req_o = rst_req_q;
   assign irq_o     = csr.ovf & ~csr.wdm;

endmodule

// File: rtl/wdog_itmr_chk.sv
module wdog_itmr_chk #(
   parameter logic [7:0] WR_KEY = 8'hA5
) (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        reg_wr_i,
   input logic [15:0] reg_wdata_i,
   input logic [7:0]  reg_rdata_o,
   input logic        irq_o,
   input logic        rst_req_o
);

   AST_RSV_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_rdata_o[4:3] == 2'b11); // R2

   AST_BAD_KEY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_wr_i && reg_wdata_i[15:8] != WR_KEY)
      |=> (reg_rdata_o[6:0] == $past(reg_rdata_o[6:0])) || rst_req_o); // R3

   AST_IRQ_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(reg_rdata_o[7]) |-> (irq_o == !reg_rdata_o[6])); // R6

   AST_IRQ_NOT_WD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_rdata_o[6] |-> !irq_o); // R6

   AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_rdata_o[7] && !(reg_wr_i && reg_wdata_i[15:8] == WR_KEY && !reg_wdata_i[7]))
      |=> reg_rdata_o[7] || rst_req_o); // R7

   AST_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_o |=> !rst_req_o); // R9

   AST_RST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_o |-> reg_rdata_o == 8'h18); // R9

endmodule

bind wdog_itmr wdog_itmr_chk #(.WR_KEY(WR_KEY)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .reg_wr_i    (reg_wr_i),
   .reg_wdata_i (reg_wdata_i),
   .reg_rdata_o (reg_rdata_o),
   .irq_o       (irq_o),
   .rst_req_o   (rst_req_o)
);

// File: tb/wdog_itmr_tb.sv
`timescale 1ns/1ps
module wdog_itmr_tb_top;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        reg_wr_i = 1'b0;
   logic [15:0] reg_wdata_i = '0;
   logic        reg_rd_i = 1'b0;
   logic [7:0]  reg_rdata_o;
   logic        rst_gen_en_i = 1'b0;
   logic        irq_o;
   logic        rst_req_o;

   int unsigned total = 0;
   int unsigned bad = 0;
   int unsigned ncyc = 0;

   always #4 clk_i = ~clk_i;
   always @(posedge clk_i) ncyc <= ncyc + 1;

   wdog_itmr dut_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .reg_wr_i     (reg_wr_i),
      .reg_wdata_i  (reg_wdata_i),
      .reg_rd_i     (reg_rd_i),
      .reg_rdata_o  (reg_rdata_o),
      .rst_gen_en_i (rst_gen_en_i),
      .irq_o        (irq_o),
      .rst_req_o    (rst_req_o)
   );

   function automatic logic [7:0] exp_rd(input logic f, input logic m, input logic e,
                                         input logic [2:0] s);
      return {f, m, e, 2'b11, s};
   endfunction

   function automatic int unsigned div_of(input int unsigned c);
      case (c)
         0: return 2;      1: return 64;     2: return 128;    3: return 512;
         4: return 2048;   5: return 8192;   6: return 32768;  default: return 131072;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int unsigned n);
      repeat (n) @(negedge clk_i);
   endtask

   task automatic wr(input logic [15:0] d);
      reg_wr_i = 1'b1; reg_wdata_i = d;
      @(negedge clk_i);
      reg_wr_i = 1'b0;
   endtask

   task automatic rd();
      reg_rd_i = 1'b1;
      @(negedge clk_i);
      reg_rd_i = 1'b0;
   endtask

   task automatic wait_irq(input int unsigned lim, output int unsigned t);
      t = 0;
      for (int unsigned i = 0; i < lim; i++) begin
         @(negedge clk_i);
         if (irq_o) begin t = ncyc; break; end
      end
   endtask

   initial begin : p_watchdog
      repeat (190000) @(posedge clk_i);
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : p_main
      logic [7:0]  prev;
      logic [7:0]  v;
      logic [7:0]  k;
      int unsigned t0, t1, t2, d, n_irq, n_rst;

      void'($urandom(32'd1234));
      cyc(5);
      rst_ni = 1'b1;
      cyc(1);
      chk("R1 reset value", reg_rdata_o, 8'h18);
      chk("R1 irq at reset", irq_o, 1'b0);
      chk("R1 rst_req at reset", rst_req_o, 1'b0);

      // constrained random writes, counter kept stopped
      for (int i = 0; i < 40; i++) begin
         prev = reg_rdata_o;
         v = 8'($urandom());
         k = 8'($urandom());
         if (k == 8'hA5) k = 8'h5A;
         wr({k, v});
         chk("R3 bad key ignored", reg_rdata_o, prev);
         v[5] = 1'b0;
         wr({8'hA5, v});
         chk("R2 R11 keyed write readback", reg_rdata_o, exp_rd(1'b0, v[6], 1'b0, v[2:0]));
      end

      // stopped counter never overflows
      wr(16'hA518);
      cyc(2000);
      chk("R4 no overflow while stopped", reg_rdata_o[7], 1'b0);

      // interval period for codes 0..2
      for (int unsigned c = 0; c < 3; c++) begin
         d = div_of(c);
         wr({8'hA5, 8'h38 | 8'(c)});
         t0 = ncyc;
         wait_irq(256 * d + 10, t1);
         chk("R6 irq on overflow", irq_o, 1'b1);
         chk("R4 first overflow window",
             32'((t1 - t0) >= 255 * d && (t1 - t0) <= 256 * d), 32'd1);
         rd();
         wr({8'hA5, 8'h38 | 8'(c)});
         chk("R7 handshake clears flag", reg_rdata_o[7], 1'b0);
         chk("R6 irq follows flag", irq_o, 1'b0);
         wait_irq(256 * d + 10, t2);
         chk("R5 overflow period", t2 - t1, 256 * d);
         rd();
         wr(16'hA518);
      end

      // handshake corner cases on code 0
      wr(16'hA538);
      wait_irq(600, t1);
      wr(16'hA538);
      chk("R7 clear without read ignored", reg_rdata_o[7], 1'b1);
      rd();
      wr(16'h1238);
      chk("R3 bad key does not clear", reg_rdata_o[7], 1'b1);
      wr(16'hA5B8);
      chk("R11 writing one keeps flag", reg_rdata_o[7], 1'b1);
      rd();
      wr(16'hA538);
      chk("R7 read then write zero clears", reg_rdata_o[7], 1'b0);
      wait_irq(600, t1);
      cyc(495);
      rd();
      cyc(30);
      wr(16'hA538);
      chk("R8 overflow cancels armed clear", reg_rdata_o[7], 1'b1);
      rd();
      wr(16'hA538);
      chk("R8 re-armed clear works", reg_rdata_o[7], 1'b0);
      wr(16'hA518);

      // watchdog mode without reset generation
      rst_gen_en_i = 1'b0;
      wr(16'hA578);
      n_irq = 0; n_rst = 0;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk_i);
         if (irq_o) n_irq++;
         if (rst_req_o) n_rst++;
      end
      chk("R10 flag set in watchdog mode", reg_rdata_o[7], 1'b1);
      chk("R10 R6 no irq in watchdog mode", n_irq, 0);
      chk("R10 no reset when generation off", n_rst, 0);
      rd();
      wr(16'hA518);
      chk("R7 cleared and stopped", reg_rdata_o, 8'h18);

      // watchdog mode with reset generation
      rst_gen_en_i = 1'b1;
      wr(16'hA57B & 16'hFFF8);
      n_rst = 0;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk_i);
         if (rst_req_o) begin
            n_rst++;
            chk("R9 register reset on request", reg_rdata_o, 8'h18);
            @(negedge clk_i);
            chk("R9 request lasts one cycle", rst_req_o, 1'b0);
            break;
         end
      end
      chk("R9 reset request seen", n_rst, 1);
      n_rst = 0;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk_i);
         if (rst_req_o) n_rst++;
      end
      chk("R9 R4 no request after reset", n_rst, 0);
      chk("R9 flag cleared by reset", reg_rdata_o[7], 1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule